// File: doc/BRIEF.md
# Manchester Frame Transmitter for a Two-Wire Lighting Bus

This block sends one forward frame at a time onto a two-wire lighting-control bus, coded as Manchester (bi-phase). Software uses a simple register write port. It loads a 32-bit transmit word as two 16-bit halves and picks a frame length. It sets the bit timing from a prescaler code and a 7-bit divisor, enables the transmitter and then writes a start command. The block sends a start bit of logical 1. It then sends the selected number of low-order bits of the word, most significant bit first, and holds the line high for two bit periods as the stop condition. At that point it raises a sticky end-of-frame flag.

A static hold function can replace the serial waveform on the pin with a fixed level. The transmit word flows in through the same write port as the control fields. There is no back-pressure: a start command is taken only when the transmitter is idle, enabled and set to a legal length, and in every other case it is dropped. Control and status pins are plain levels.

Top module: `mtx_top`

## Requirements
- R1: After reset, and whenever no frame is in progress and hold is off, `tx_pin` is high, and `tx_busy` and `tx_end` are low.
- R2: Length code (config bits [2:0]) selects 8, 16, 24, 32, 20 or 17 data bits for codes 0, 1, 2, 3, 4 and 5. The data bits are bits [n-1:0] of the word {upper half (address 0), lower half (address 1)}.
- R3: One half-bit lasts (div+1)·4^ps clock cycles. Here ps is config bits [4:3] and div is config bits [11:5].
- R4: Each bit is two half-bits: logical 1 is low then high, logical 0 is high then low. The start bit (1) comes first, followed by the data bits MSB first. The first half-bit begins on the edge that accepts the start command.
- R5: After the last data bit, the line stays high for 4 half-bits. On the edge ending that stop time, `tx_busy` falls and `tx_end` rises.
- R6: `tx_end` stays set until a write to address 4 with bit 1 set. A write to address 4 with value 0 changes nothing.
- R7: A start command (address 4, bit 0) with length code 6 or 7 does not start a frame.
- R8: A start command while enable (control bit 0, address 3) is 0 does not start a frame.
- R9: A start command while a frame is in progress is ignored. The frame in progress continues unchanged.
- R10: With hold enable (control bit 1) set, `tx_pin` equals hold level (control bit 2) whatever the serial state.
- R11: Clearing enable during a frame ends it on the next edge: the line returns high, `tx_busy` falls and `tx_end` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 upper data, 1 lower data, 2 config, 3 control, 4 command |
| wr_data | input | 16 | Write data |
| tx_pin | output | 1 | Bus transmit pin |
| tx_busy | output | 1 | Frame in progress |
| tx_end | output | 1 | Sticky end-of-frame flag |

## Verification
The assertions assume the following: config and hold fields are written only while no frame is in progress, `wr_addr` values above 4 are never relied on, and reset is applied before the first write. The stimulus programs the word, timing and control before each start command. During a frame it writes only the command register, or clears enable on purpose. Prescaler and divisor are drawn from small ranges so that frames stay short, and one directed frame uses the largest prescaler.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  localparam int unsigned HALF_W     = 16;
  localparam int unsigned WORD_W     = 2 * HALF_W;
  localparam int unsigned CODE_W     = 3;
  localparam int unsigned PS_W       = 2;
  localparam int unsigned DIV_W      = 7;
  localparam int unsigned NB_W       = $clog2(WORD_W + 2);
  localparam int unsigned TIM_W      = DIV_W + 1 + 2 * ((1 << PS_W) - 1);
  localparam int unsigned STOP_HALVES = 4;

  // number of data bits for a length code, 0 when the code is illegal
  function automatic logic [NB_W-1:0] code_bits(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    code_bits = NB_W'(8);
      3'd1:    code_bits = NB_W'(16);
      3'd2:    code_bits = NB_W'(24);
      3'd3:    code_bits = NB_W'(32);
      3'd4:    code_bits = NB_W'(20);
      3'd5:    code_bits = NB_W'(17);
      default: code_bits = '0;
    endcase
  endfunction
endpackage

// File: rtl/mtx_half_timer.sv
module mtx_half_timer
  import mtx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [PS_W-1:0]  ps,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [TIM_W-1:0] cnt, lim, span;

  always_comb span = (TIM_W'(div) + TIM_W'(1)) << {ps, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      lim <= '0;
    end else if (load) begin
      cnt <= '0;
      lim <= span - TIM_W'(1);
    end else if (run) begin
      cnt <= tick ? '0 : cnt + TIM_W'(1);
    end
  end

  assign tick = run && (cnt == lim);

  // R3: the half-bit counter never passes its latched limit
  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= lim));
endmodule

// File: rtl/mtx_serializer.sv
module mtx_serializer
  import mtx_pkg::*;
#(
  parameter int unsigned FW = WORD_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            abort,
  input  logic            tick,
  input  logic [FW-1:0]   frame,
  input  logic [NB_W-1:0] nbits,
  output logic            line,
  output logic            busy,
  output logic            done
);
  localparam int unsigned SC_W = $clog2(STOP_HALVES + 1);

  logic [FW-1:0]   shreg;
  logic [NB_W-1:0] bits_left;
  logic            phase, in_stop;
  logic [SC_W-1:0] stop_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; line <= 1'b1; shreg <= '0; bits_left <= '0;
      phase <= 1'b0; in_stop <= 1'b0; stop_cnt <= '0;
    end else if (abort) begin
      busy <= 1'b0; line <= 1'b1; in_stop <= 1'b0;
    end else if (load) begin
      busy      <= 1'b1;
      shreg     <= frame;
      bits_left <= nbits + NB_W'(1);
      phase     <= 1'b0;
      in_stop   <= 1'b0;
      stop_cnt  <= '0;
      line      <= ~frame[FW-1];
    end else if (busy && tick) begin
      if (in_stop) begin
        stop_cnt <= stop_cnt + SC_W'(1);
        if (stop_cnt == SC_W'(STOP_HALVES - 1)) busy <= 1'b0;
      end else if (!phase) begin
        phase <= 1'b1;
        line  <= shreg[FW-1];
      end else begin
        phase     <= 1'b0;
        shreg     <= shreg << 1;
        bits_left <= bits_left - NB_W'(1);
        if (bits_left == NB_W'(1)) begin
          in_stop  <= 1'b1;
          stop_cnt <= '0;
          line     <= 1'b1;
        end else begin
          line <= ~shreg[FW-2];
        end
      end
    end
  end

  assign done = busy && tick && in_stop && !abort &&
                (stop_cnt == SC_W'(STOP_HALVES - 1));

  // R4: the line only moves on a half-bit boundary
  a_r4_line_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !abort) |=> $stable(line));
  // R1: an idle serializer holds the line high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line);
  // R5: the end of the stop time closes the frame
  a_r5_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/mtx_top.sv
module mtx_top
  import mtx_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  output logic              tx_pin,
  output logic              tx_busy,
  output logic              tx_end
);
  localparam int unsigned FW       = WORD_W + 1;
  localparam int unsigned CFG_USED = CODE_W + PS_W + DIV_W;

  logic [HALF_W-1:0] data_hi, data_lo;
  logic [CODE_W-1:0] len_code;
  logic [PS_W-1:0]   ps;
  logic [DIV_W-1:0]  div;
  logic              enable, hold_en, hold_lvl, end_q;
  logic              unused_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_hi <= '0; data_lo <= '0; len_code <= '0; ps <= '0; div <= '0;
      enable <= 1'b0; hold_en <= 1'b0; hold_lvl <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_W'(0): data_hi <= wr_data;
        ADDR_W'(1): data_lo <= wr_data;
        ADDR_W'(2): begin
          len_code <= wr_data[CODE_W-1:0];
          ps       <= wr_data[CODE_W +: PS_W];
          div      <= wr_data[CODE_W+PS_W +: DIV_W];
        end
        ADDR_W'(3): begin
          enable   <= wr_data[0];
          hold_en  <= wr_data[1];
          hold_lvl <= wr_data[2];
        end
        default: ;
      endcase
    end
  end

  assign unused_bits = ^wr_data[HALF_W-1:CFG_USED];

  logic            cmd_wr, start_wr, clear_wr, len_ok, load, abort, tick, line, done;
  logic [NB_W-1:0] nbits;
  logic [FW-1:0]   frame;

  assign cmd_wr   = wr_en && (wr_addr == ADDR_W'(4));
  assign start_wr = cmd_wr && wr_data[0];
  assign clear_wr = cmd_wr && wr_data[1];
  assign nbits    = code_bits(len_code);
  assign len_ok   = (nbits != '0);
  assign load     = start_wr && enable && len_ok && !tx_busy;
  assign abort    = tx_busy && !enable;
  assign frame    = {1'b1, {data_hi, data_lo} << (NB_W'(WORD_W) - nbits)};

  mtx_half_timer u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .run(tx_busy),
    .ps(ps), .div(div), .tick(tick)
  );

  mtx_serializer #(.FW(FW)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(load), .abort(abort), .tick(tick),
    .frame(frame), .nbits(nbits), .line(line), .busy(tx_busy), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        end_q <= 1'b0;
    else if (done)     end_q <= 1'b1;
    else if (clear_wr) end_q <= 1'b0;
  end

  assign tx_end = end_q;
  assign tx_pin = hold_en ? hold_lvl : line;

  // R5: a finished frame raises the end flag
  a_r5_end_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> tx_end);
  // R7: an illegal length never starts a frame
  a_r7_bad_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && start_wr && !len_ok) |=> !tx_busy);
  // R9: a start during a frame does not end it
  a_r9_start_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && start_wr && enable && !done) |=> tx_busy);
  // R6: the flag only drops on a clear command
  a_r6_end_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_end && !clear_wr) |=> tx_end);
endmodule

// File: tb/sim_mtx_top.sv
module sim_mtx_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        tx_pin, tx_busy, tx_end;
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;

  always #10 clk = ~clk;

  mtx_top u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
              .wr_data(wr_data), .tx_pin(tx_pin), .tx_busy(tx_busy), .tx_end(tx_end));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int blen(input int code);
    case (code)
      0: return 8;  1: return 16; 2: return 24;
      3: return 32; 4: return 20; 5: return 17;
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_half(input logic [31:0] w, input int n, input int k);
    bit b;
    if (k >= 2 * n + 2) return 1'b1;
    b = (k / 2 == 0) ? 1'b1 : w[n - k / 2];
    return (k % 2 == 0) ? ~b : b;
  endfunction

  function automatic logic [15:0] cfg(input int code, input int ps, input int dv);
    return 16'(code) | 16'(ps << 3) | 16'(dv << 5);
  endfunction

  // one full frame, pin compared every cycle; inject issues a second start mid-frame
  task automatic run_frame(input int code, input int ps, input int dv,
                           input logic [31:0] w, input bit inject, input string req);
    int n, h, halves, miss_c, act, expv;
    bit ok;
    n = blen(code); h = (dv + 1) * (1 << (2 * ps)); halves = 2 * n + 6;
    wr(3'd4, 16'h0002);
    wr(3'd0, w[31:16]); wr(3'd1, w[15:0]);
    wr(3'd2, cfg(code, ps, dv)); wr(3'd3, 16'h0001);
    wr(3'd4, 16'h0001);
    ok = 1; miss_c = -1; act = 0; expv = 0;
    for (int c = 0; c < halves * h; c++) begin
      if (wr_en) wr_en = 1'b0;
      if (ok && (tx_pin !== exp_half(w, n, c / h) || tx_busy !== 1'b1)) begin
        ok = 0; miss_c = c; act = tx_pin; expv = exp_half(w, n, c / h);
      end
      if (inject && c == 3 * h + 1) begin
        wr_en = 1'b1; wr_addr = 3'd4; wr_data = 16'h0001;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    if (!ok) $display("  mismatch at cycle %0d", miss_c);
    check(ok, req, act, expv);
    check(tx_busy == 1'b0 && tx_end == 1'b1 && tx_pin == 1'b1, "R5",
          {tx_busy, tx_end, tx_pin}, 3'b011);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(tx_pin == 1'b1 && tx_busy == 1'b0 && tx_end == 1'b0, "R1",
          {tx_pin, tx_busy, tx_end}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_pin == 1'b1 && tx_busy == 1'b0 && tx_end == 1'b0, "R1",
          {tx_pin, tx_busy, tx_end}, 3'b100);

    // R2 every legal length code
    for (int code = 0; code < 6; code++)
      run_frame(code, $urandom_range(1, 0), $urandom_range(3, 0), $urandom, 0, "R2");
    run_frame(3, 0, 0, 32'h8000_0001, 0, "R2");
    run_frame(5, 0, 2, 32'hFFFE_FFFF, 0, "R2");

    // R3 largest prescaler, and fastest timing
    run_frame(0, 3, 1, 32'h0000_00A5, 0, "R3");
    run_frame(1, 0, 0, 32'h0000_F00F, 0, "R3");

    // R6 sticky flag, write of zero, then clear
    repeat (40) @(negedge clk);
    check(tx_end == 1'b1, "R6", tx_end, 1);
    wr(3'd4, 16'h0000);
    repeat (5) @(negedge clk);
    check(tx_end == 1'b1 && tx_busy == 1'b0 && tx_pin == 1'b1, "R6",
          {tx_end, tx_busy, tx_pin}, 3'b101);
    wr(3'd4, 16'h0002);
    check(tx_end == 1'b0, "R6", tx_end, 0);

    // R7 illegal length codes
    for (int code = 6; code < 8; code++) begin
      bit ok7 = 1;
      wr(3'd2, cfg(code, 0, 0)); wr(3'd3, 16'h0001); wr(3'd4, 16'h0001);
      for (int c = 0; c < 20; c++) begin
        if (tx_busy !== 1'b0 || tx_pin !== 1'b1) ok7 = 0;
        @(negedge clk);
      end
      check(ok7 && tx_end == 1'b0, "R7", {tx_busy, tx_pin}, 2'b01);
    end

    // R8 start while disabled
    begin
      bit ok8 = 1;
      wr(3'd2, cfg(0, 0, 0)); wr(3'd3, 16'h0000); wr(3'd4, 16'h0001);
      for (int c = 0; c < 20; c++) begin
        if (tx_busy !== 1'b0 || tx_pin !== 1'b1) ok8 = 0;
        @(negedge clk);
      end
      check(ok8 && tx_end == 1'b0, "R8", {tx_busy, tx_pin}, 2'b01);
    end

    // R9 start during a frame
    run_frame(2, 0, 1, 32'h00C3_5A96, 1, "R9");
    run_frame(4, 1, 0, 32'h000F_1234, 1, "R9");

    // R10 hold level overrides the pin
    wr(3'd3, 16'h0002);
    check(tx_pin == 1'b0, "R10", tx_pin, 0);
    wr(3'd3, 16'h0006);
    check(tx_pin == 1'b1, "R10", tx_pin, 1);
    wr(3'd3, 16'h0002);
    check(tx_pin == 1'b0, "R10", tx_pin, 0);
    wr(3'd3, 16'h0000);
    check(tx_pin == 1'b1, "R10", tx_pin, 1);

    // R11 enable cleared mid-frame
    wr(3'd4, 16'h0002);
    wr(3'd0, 16'h0000); wr(3'd1, 16'h0000);
    wr(3'd2, cfg(0, 0, 3)); wr(3'd3, 16'h0001); wr(3'd4, 16'h0001);
    repeat (10) @(negedge clk);
    check(tx_busy == 1'b1, "R11", tx_busy, 1);
    wr(3'd3, 16'h0000);
    @(negedge clk);
    check(tx_busy == 1'b0 && tx_pin == 1'b1, "R11", {tx_busy, tx_pin}, 2'b01);
    repeat (60) @(negedge clk);
    check(tx_end == 1'b0 && tx_pin == 1'b1, "R11", {tx_end, tx_pin}, 2'b01);

    // R4 random frames
    for (int i = 0; i < 12; i++)
      run_frame($urandom_range(5, 0), $urandom_range(1, 0), $urandom_range(3, 0),
                $urandom, 0, "R4");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule